// File: doc/BRIEF.md
# Taken-Branch Trace Recorder with Loop Timer

This block keeps a rolling history of the most recent taken branches retired by a core. Every record holds the address of the branch, the address it jumped to, and the value of a free-running cycle counter at the moment it retired. Because only taken branches are kept, consecutive records bound one straight-line run of code. Software reads the history by age, from the newest record backwards. A freeze input stops recording so that a stable snapshot can be read out.

A loop timer sits beside the history and watches the same branch stream. Software programs two branch addresses: one that closes an outer loop and one that closes an inner loop. Each time the outer branch retires again, the timer reports two values. The first is the number of cycles since the previous outer occurrence. The second is how many inner-branch occurrences fell between the two. Both values arrive together with a one-cycle strobe.

Profiling logic uses the two outputs to build a distribution of iteration times and trip counts without post-processing the raw history. The history depth must be a power of two for the simplest pointer arithmetic, but other depths are also supported.

Top module: `taken_branch_recorder`

## Requirements
- R1: After reset, fill_cnt is 0, meas_valid is 0 and rd_hit is 0.
- R2: A cycle with br_taken low records nothing, so fill_cnt and the stored history are unchanged.
- R3: Each record holds br_pc, br_tgt and a timestamp. The difference between the timestamps of two records equals the number of clock cycles between their retirement cycles, taken modulo 2^TS_W.
- R4: rd_idx = 0 selects the newest record and rd_idx = k selects the record k places older. rd_pc, rd_tgt, rd_ts and rd_hit are valid one cycle after rd_idx is presented. rd_hit is 1 only when rd_idx < fill_cnt.
- R5: The history is circular. fill_cnt saturates at DEPTH, and once it is full each new record replaces the oldest one, so that rd_idx = DEPTH-1 returns the oldest surviving record.
- R6: While freeze is high, taken branches are not recorded, so fill_cnt and the read results do not change. Recording resumes when freeze falls.
- R7: When br_taken is high with br_pc equal to the programmed outer address and an earlier outer occurrence exists, meas_valid is high for exactly the following cycle. In that cycle meas_cycles equals the cycle distance between the two outer occurrences.
- R8: meas_inner equals the number of taken branches matching the inner address between the two outer occurrences. The count restarts from zero at every outer occurrence.
- R9: A cfg_we cycle loads both watched addresses and clears the timer history. The first outer occurrence after a reset or a cfg_we produces no strobe, and the cycle after a cfg_we never carries a strobe.
- R10: freeze has no effect on the loop timer, which keeps measuring while recording is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_taken | input | 1 | A taken branch retires this cycle |
| br_pc | input | ADDR_W | Address of the retiring branch |
| br_tgt | input | ADDR_W | Target address of the retiring branch |
| cfg_we | input | 1 | Load the watched branch addresses |
| cfg_outer_pc | input | ADDR_W | Outer-loop branch address |
| cfg_inner_pc | input | ADDR_W | Inner-loop branch address |
| freeze | input | 1 | Stop recording into the history |
| rd_idx | input | $clog2(DEPTH) | Age of the record to read (0 = newest) |
| rd_hit | output | 1 | Selected record exists |
| rd_pc | output | ADDR_W | Branch address of the selected record |
| rd_tgt | output | ADDR_W | Target address of the selected record |
| rd_ts | output | TS_W | Timestamp of the selected record |
| fill_cnt | output | $clog2(DEPTH+1) | Number of valid records |
| meas_valid | output | 1 | One-cycle strobe for a new loop measurement |
| meas_cycles | output | TS_W | Cycles between consecutive outer occurrences |
| meas_inner | output | CNT_W | Inner occurrences in that outer iteration |

## Verification
Every result is registered once. A branch presented in a cycle appears in fill_cnt and in the loop outputs right after the next rising edge. A read index presented in a cycle returns its record after that same edge. The bench changes inputs on the falling edge and samples one nanosecond after the following rising edge, so each check lands on the cycle its result is due. While idle cycles follow a branch, the bench confirms that the loop strobe stays low, so that a strobe arriving late or held for too long is caught.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_TS_W   = 32;
  localparam int unsigned DEF_CNT_W  = 16;

  typedef enum logic {
    MS_IDLE  = 1'b0,
    MS_ARMED = 1'b1
  } meter_st_e;
endpackage

// File: rtl/tbr_cycle_ctr.sv
module tbr_cycle_ctr #(
  parameter int unsigned TS_W = tbr_pkg::DEF_TS_W
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + TS_W'(1);
  end
endmodule

// File: rtl/tbr_ring.sv
module tbr_ring #(
  parameter int unsigned DEPTH  = tbr_pkg::DEF_DEPTH,
  parameter int unsigned ADDR_W = tbr_pkg::DEF_ADDR_W,
  parameter int unsigned TS_W   = tbr_pkg::DEF_TS_W,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_pc,
  output logic [ADDR_W-1:0] rd_tgt,
  output logic [TS_W-1:0]   rd_ts,
  output logic [FILL_W-1:0] fill
);
  localparam int unsigned REC_W   = 2 * ADDR_W + TS_W;
  localparam bit          IS_POW2 = ((1 << PTR_W) == DEPTH);
  localparam int          DEPTH_I = int'(DEPTH);

  logic [REC_W-1:0] mem [DEPTH];
  logic [REC_W-1:0] rd_q;
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] wp_nxt;
  logic [PTR_W-1:0] raddr;

  generate
    if (IS_POW2) begin : g_pow2
      assign wp_nxt = wp + PTR_W'(1);
      assign raddr  = wp - PTR_W'(1) - rd_idx;
    end else begin : g_any
      int back;
      assign wp_nxt = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      always_comb begin
        back = int'(wp) + DEPTH_I - 1 - int'(rd_idx);
        if (back < 0)        back = back + DEPTH_I;
        if (back >= DEPTH_I) back = back - DEPTH_I;
      end
      assign raddr = PTR_W'(back);
    end
  endgenerate

  // storage: synchronous write and synchronous read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= {wr_pc, wr_tgt, wr_ts};
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      fill   <= '0;
      rd_hit <= 1'b0;
    end else begin
      rd_hit <= (FILL_W'(rd_idx) < fill);
      if (wr_en) begin
        wp <= wp_nxt;
        if (fill != FILL_W'(DEPTH)) fill <= fill + FILL_W'(1);
      end
    end
  end

  assign rd_pc  = rd_q[REC_W-1 -: ADDR_W];
  assign rd_tgt = rd_q[TS_W +: ADDR_W];
  assign rd_ts  = rd_q[TS_W-1:0];
endmodule

// File: rtl/tbr_loop_meter.sv
module tbr_loop_meter
  import tbr_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned TS_W   = DEF_TS_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_outer,
  input  logic [ADDR_W-1:0] cfg_inner,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [TS_W-1:0]   br_ts,
  output logic              meas_valid,
  output logic [TS_W-1:0]   meas_cycles,
  output logic [CNT_W-1:0]  meas_inner
);
  meter_st_e         st;
  logic [ADDR_W-1:0] outer_q;
  logic [ADDR_W-1:0] inner_q;
  logic [TS_W-1:0]   last_ts;
  logic [CNT_W-1:0]  icnt;
  logic              hit_outer;
  logic              hit_inner;

  assign hit_outer = br_taken && (br_pc == outer_q);
  assign hit_inner = br_taken && (br_pc == inner_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= MS_IDLE;
      outer_q     <= '0;
      inner_q     <= '0;
      last_ts     <= '0;
      icnt        <= '0;
      meas_valid  <= 1'b0;
      meas_cycles <= '0;
      meas_inner  <= '0;
    end else begin
      meas_valid <= 1'b0;
      if (cfg_we) begin
        outer_q <= cfg_outer;
        inner_q <= cfg_inner;
        st      <= MS_IDLE;
        icnt    <= '0;
      end else if (hit_outer) begin
        if (st == MS_ARMED) begin
          meas_valid  <= 1'b1;
          meas_cycles <= br_ts - last_ts;  // modular difference
          meas_inner  <= icnt;
        end
        last_ts <= br_ts;
        st      <= MS_ARMED;
        icnt    <= '0;
      end else if (hit_inner && (icnt != '1)) begin
        icnt <= icnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/taken_branch_recorder.sv
module taken_branch_recorder
  import tbr_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned TS_W   = DEF_TS_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       br_taken,
  input  logic [ADDR_W-1:0]          br_pc,
  input  logic [ADDR_W-1:0]          br_tgt,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_outer_pc,
  input  logic [ADDR_W-1:0]          cfg_inner_pc,
  input  logic                       freeze,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic                       rd_hit,
  output logic [ADDR_W-1:0]          rd_pc,
  output logic [ADDR_W-1:0]          rd_tgt,
  output logic [TS_W-1:0]            rd_ts,
  output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  output logic                       meas_valid,
  output logic [TS_W-1:0]            meas_cycles,
  output logic [CNT_W-1:0]           meas_inner
);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W  = $clog2(DEPTH);

  logic [TS_W-1:0] now_ts;
  logic            rec_en;

  assign rec_en = br_taken && !freeze;

  tbr_cycle_ctr #(.TS_W(TS_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .ts  (now_ts)
  );

  tbr_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (rec_en),
    .wr_pc  (br_pc),
    .wr_tgt (br_tgt),
    .wr_ts  (now_ts),
    .rd_idx (rd_idx),
    .rd_hit (rd_hit),
    .rd_pc  (rd_pc),
    .rd_tgt (rd_tgt),
    .rd_ts  (rd_ts),
    .fill   (fill_cnt)
  );

  tbr_loop_meter #(.ADDR_W(ADDR_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_outer   (cfg_outer_pc),
    .cfg_inner   (cfg_inner_pc),
    .br_taken    (br_taken),
    .br_pc       (br_pc),
    .br_ts       (now_ts),
    .meas_valid  (meas_valid),
    .meas_cycles (meas_cycles),
    .meas_inner  (meas_inner)
  );
endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned FILL_W = 6,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              br_taken,
  input logic              freeze,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              rd_hit,
  input logic [FILL_W-1:0] fill_cnt,
  input logic              meas_valid
);
  a_r5_fill_cap: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= FILL_W'(DEPTH));

  a_r5_fill_grow: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !freeze && (fill_cnt < FILL_W'(DEPTH)))
      |=> (fill_cnt == $past(fill_cnt) + FILL_W'(1)));

  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (fill_cnt == $past(fill_cnt)));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (fill_cnt == $past(fill_cnt)));

  a_r4_hit_range: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> ($past(FILL_W'(rd_idx)) < $past(fill_cnt)));

  a_r7_strobe_source: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> $past(br_taken && !cfg_we));

  a_r9_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !meas_valid);
endmodule

bind taken_branch_recorder tbr_checker #(
  .DEPTH(DEPTH), .FILL_W(FILL_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .br_taken   (br_taken),
  .freeze     (freeze),
  .cfg_we     (cfg_we),
  .rd_idx     (rd_idx),
  .rd_hit     (rd_hit),
  .fill_cnt   (fill_cnt),
  .meas_valid (meas_valid)
);

// File: tb/taken_branch_recorder_test.sv
module taken_branch_recorder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        br_taken;
  logic [31:0] br_pc, br_tgt;
  logic        cfg_we;
  logic [31:0] cfg_outer_pc, cfg_inner_pc;
  logic        freeze;
  logic [4:0]  rd_idx;
  logic        rd_hit;
  logic [31:0] rd_pc, rd_tgt, rd_ts;
  logic [5:0]  fill_cnt;
  logic        meas_valid;
  logic [31:0] meas_cycles;
  logic [15:0] meas_inner;

  int total = 0;
  int bad = 0;
  int step_no = 0;
  int ev_step [8];
  logic frz_next = 1'b0;
  logic [31:0] ts_a;

  always #2 clk = ~clk;

  taken_branch_recorder uut (
    .clk(clk), .rst(rst), .br_taken(br_taken), .br_pc(br_pc), .br_tgt(br_tgt),
    .cfg_we(cfg_we), .cfg_outer_pc(cfg_outer_pc), .cfg_inner_pc(cfg_inner_pc),
    .freeze(freeze), .rd_idx(rd_idx), .rd_hit(rd_hit), .rd_pc(rd_pc),
    .rd_tgt(rd_tgt), .rd_ts(rd_ts), .fill_cnt(fill_cnt), .meas_valid(meas_valid),
    .meas_cycles(meas_cycles), .meas_inner(meas_inner)
  );

  // fields: pc[71:40] gap[39:32] exp_valid[31:24] exp_inner[23:16] exp_cycles[15:0]
  localparam logic [71:0] VEC [8] = '{
    {32'h100, 8'd2, 8'd0, 8'd0, 16'd0},
    {32'h200, 8'd0, 8'd0, 8'd0, 16'd0},
    {32'h200, 8'd1, 8'd0, 8'd0, 16'd0},
    {32'h300, 8'd0, 8'd0, 8'd0, 16'd0},
    {32'h100, 8'd3, 8'd1, 8'd2, 16'd7},
    {32'h100, 8'd0, 8'd1, 8'd0, 16'd4},
    {32'h200, 8'd4, 8'd0, 8'd0, 16'd0},
    {32'h100, 8'd1, 8'd1, 8'd1, 16'd6}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] pc, logic [31:0] tgt);
    @(negedge clk);
    br_taken = v; br_pc = pc; br_tgt = tgt;
    cfg_we = 1'b0; freeze = frz_next;
    @(posedge clk); #1;
    step_no++;
  endtask

  task automatic rd_step(logic [4:0] idx);
    @(negedge clk);
    br_taken = 1'b0; cfg_we = 1'b0; freeze = frz_next; rd_idx = idx;
    @(posedge clk); #1;
    step_no++;
  endtask

  task automatic cfg_step(logic [31:0] outer, logic [31:0] inner);
    @(negedge clk);
    br_taken = 1'b0; cfg_we = 1'b1; freeze = frz_next;
    cfg_outer_pc = outer; cfg_inner_pc = inner;
    @(posedge clk); #1;
    step_no++;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst = 1'b1; br_taken = 0; br_pc = 0; br_tgt = 0; cfg_we = 0;
    cfg_outer_pc = 0; cfg_inner_pc = 0; freeze = 0; rd_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 fill", fill_cnt, 0);
    chk("R1 meas_valid", meas_valid, 0);
    chk("R1 rd_hit", rd_hit, 0);

    cfg_step(32'h100, 32'h200);
    for (int i = 0; i < 8; i++) begin
      logic [71:0] v;
      v = VEC[i];
      step(1'b1, v[71:40], v[71:40] + 32'h40 + 32'(i));
      ev_step[i] = step_no;
      chk(v[24] ? "R7 strobe" : "R9 first/no strobe", meas_valid, v[24]);
      if (v[24]) begin
        chk("R7 cycles", meas_cycles, v[15:0]);
        chk("R8 inner", meas_inner, v[23:16]);
      end
      for (int g = 0; g < int'(v[39:32]); g++) begin
        step(1'b0, 32'h0, 32'h0);
        chk("R7 one-cycle strobe", meas_valid, 0);
      end
    end
    chk("R2 idle not recorded", fill_cnt, 8);

    rd_step(5'd0);
    chk("R4 hit newest", rd_hit, 1);
    chk("R4 newest pc", rd_pc, 32'h100);
    chk("R3 newest tgt", rd_tgt, 32'h147);
    ts_a = rd_ts;
    rd_step(5'd1);
    chk("R4 second pc", rd_pc, 32'h200);
    chk("R3 second tgt", rd_tgt, 32'h246);
    chk("R3 ts distance", ts_a - rd_ts, 32'(ev_step[7] - ev_step[6]));
    rd_step(5'd7);
    chk("R4 oldest pc", rd_pc, 32'h100);
    chk("R3 oldest tgt", rd_tgt, 32'h140);
    rd_step(5'd8);
    chk("R4 beyond fill", rd_hit, 0);

    for (int n = 0; n < 30; n++) step(1'b1, 32'h1000 + 32'(n), 32'h2000 + 32'(n));
    chk("R5 fill saturates", fill_cnt, 32);
    rd_step(5'd0);
    chk("R5 newest after wrap", rd_pc, 32'h101D);
    rd_step(5'd31);
    chk("R5 oldest survivor pc", rd_pc, 32'h200);
    chk("R5 oldest survivor tgt", rd_tgt, 32'h246);

    frz_next = 1'b1;
    step(1'b1, 32'hDEAD, 32'hBEEF);
    step(1'b0, 32'h0, 32'h0);
    chk("R6 frozen fill", fill_cnt, 32);
    rd_step(5'd0);
    chk("R6 frozen newest", rd_pc, 32'h101D);

    cfg_step(32'h500, 32'h600);
    chk("R9 no strobe after cfg", meas_valid, 0);
    step(1'b1, 32'h500, 32'h0);
    chk("R9 first after cfg", meas_valid, 0);
    step(1'b1, 32'h600, 32'h0);
    step(1'b0, 32'h0, 32'h0);
    step(1'b1, 32'h500, 32'h0);
    chk("R10 strobe while frozen", meas_valid, 1);
    chk("R10 cycles while frozen", meas_cycles, 3);
    chk("R10 inner while frozen", meas_inner, 1);
    rd_step(5'd0);
    chk("R6 still frozen", rd_pc, 32'h101D);

    frz_next = 1'b0;
    step(1'b1, 32'h500, 32'h5A0);
    chk("R8 inner restarts", meas_inner, 0);
    chk("R7 back-to-back", meas_cycles, 2);
    rd_step(5'd0);
    chk("R6 recording resumes", rd_pc, 32'h500);
    chk("R6 fill after resume", fill_cnt, 32);

    finish_up();
  end
endmodule